// File: doc/BRIEF.md
# Frequency Synthesizer Digital Core

This block is the digital part of a frequency synthesizer loop. It runs on one system clock. Two single-cycle strobes arrive from outside: one from the RF prescaler and one from the reference oscillator. A programmable divider counts the prescaler strobes, and a reference divider with a selectable power-of-two ratio counts the reference strobes. A dual-flip-flop phase-frequency detector compares the two divided streams and produces up and down pump requests. A lock detector watches how wide those requests are.

The loop settles where the VCO frequency equals 8 × ratio × f_ref / R. For example, a 4 MHz reference with R = 512 gives 62.5 kHz channel steps. Control inputs do the following:
- disable the pump outputs while the detector keeps running;
- disable the tuning drive, which stops the whole loop;
- select the pump current;
- route the two divided pulse streams to test pins.

A divide ratio of zero also stops the whole loop. This lets a tuner be aligned with an externally supplied tuning voltage.

Top module: `synth_core`

## Requirements
- R1: While `rst_n` is low, `pump_up`, `pump_dn`, `tp_rf` and `tp_ref` are 0, and `lock_n` is 1.
- R2: While the loop is active, the divided-RF pulse is one clock wide. It follows every `div_ratio`-th `rf_tick`, and it shows on `tp_rf` one clock after the strobe that completes the count.
- R3: `ref_sel` picks the reference ratio: 2'b10 gives 2^B, 2'b11 gives 2^(B+1), 2'b01 gives 2^(B+2), and 2'b00 turns the loop off. B is `REF_BASE_LOG2`. The divided-reference pulse shows on `tp_ref` the same way R2 describes for `tp_rf`.
- R4: The up request is set the clock after a divided-reference pulse, and the down request is set the clock after a divided-RF pulse. When both are set, both clear on the next clock unless a new pulse sets one of them again.
- R5: With `pump_off` = 1, `pump_en`, `pump_up` and `pump_dn` are 0. Detector and lock tracking keep running.
- R6: With `drive_off` = 1, `drive_en` is 0. One clock later the dividers, the detector and the lock state are all cleared.
- R7: `div_ratio` = 0 stops the loop in the same way as `drive_off`.
- R8: With `test_route` = 0, `tp_rf` and `tp_ref` stay at 0.
- R9: `pump_cur_hi` follows `pump_hi` while `pump_en` is 1, and is 0 otherwise.
- R10: `lock_n` goes low after `LOCK_PERIODS` consecutive reference periods. In each of those periods, the number of clocks with an up or down request set is at most `LOCK_TOL`.
- R11: `lock_n` returns high on the clock after the request-width count of the current period passes `LOCK_TOL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_tick | input | 1 | One-cycle strobe from the RF prescaler |
| ref_tick | input | 1 | One-cycle strobe from the reference oscillator |
| div_ratio | input | SF_W | Programmable divide ratio (0 stops the loop) |
| ref_sel | input | 2 | Reference ratio code |
| pump_off | input | 1 | Forces pump outputs off |
| drive_off | input | 1 | Disables tuning drive and the loop |
| pump_hi | input | 1 | High pump current request |
| test_route | input | 1 | Routes divided pulses to test pins |
| pump_up | output | 1 | Up pump request |
| pump_dn | output | 1 | Down pump request |
| pump_en | output | 1 | Pump stage enabled (0 = high impedance) |
| pump_cur_hi | output | 1 | High pump current indicator |
| drive_en | output | 1 | Tuning drive enabled |
| lock_n | output | 1 | Lock flag, low when locked |
| tp_rf | output | 1 | Divided RF pulse on test pin |
| tp_ref | output | 1 | Divided reference pulse on test pin |

## Verification
The bench builds the block with `REF_BASE_LOG2` = 2, so the three reference ratios are 4, 8 and 16. Locking then takes tens of clocks instead of thousands. `LOCK_PERIODS` = 4 and `LOCK_TOL` = 2 make both gaining lock and losing it through a slightly wrong ratio happen within a few hundred cycles. The full 15-bit ratio width is kept, so the zero-ratio stop and the ratio-of-one corner are both exercised at the real width.

// File: rtl/synth_pkg.sv
package synth_pkg;

   typedef enum logic [1:0] {
      REF_STOP  = 2'b00,
      REF_QUAD  = 2'b01,
      REF_BASE  = 2'b10,
      REF_DOUB  = 2'b11
   } ref_code_e;

   // Shift above the base ratio exponent; -1 marks the stopped code.
   function automatic int ref_extra_shift(input logic [1:0] code);
      case (ref_code_e'(code))
         REF_BASE: ref_extra_shift = 0;
         REF_DOUB: ref_extra_shift = 1;
         REF_QUAD: ref_extra_shift = 2;
         default:  ref_extra_shift = -1;
      endcase
   endfunction

endpackage

// File: rtl/synth_rf_div.sv
module synth_rf_div #(
   parameter int SF_W = 15
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            tick,
   input  logic [SF_W-1:0] ratio,
   output logic            pulse
);
   logic [SF_W-1:0] cnt_q;
   logic [SF_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (tick) begin
            // wrap test tolerates a ratio lowered below the running count
            if (cnt_inc >= {1'b0, ratio}) begin
               cnt_q <= '0;
               pulse <= 1'b1;
            end else begin
               cnt_q <= cnt_inc[SF_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/synth_ref_div.sv
module synth_ref_div
   import synth_pkg::*;
#(
   parameter int BASE_LOG2 = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       pulse
);
   localparam int CW = BASE_LOG2 + 3;

   logic [CW-2:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   logic [CW-1:0] limit;

   always_comb begin
      int sh;
      sh = ref_extra_shift(sel);
      if (sh < 0) limit = '0;
      else        limit = CW'(1) << (BASE_LOG2 + sh);
   end

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else begin
         pulse <= 1'b0;
         if (tick) begin
            if (cnt_inc >= limit) begin
               cnt_q <= '0;
               pulse <= 1'b1;
            end else begin
               cnt_q <= cnt_inc[CW-2:0];
            end
         end
      end
   end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic ref_p,
   input  logic rf_p,
   output logic up_q,
   output logic dn_q
);
   logic both;

   assign both = up_q & dn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (!run) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         // a pulse landing in the clearing cycle is kept, not lost
         up_q <= (up_q & ~both) | ref_p;
         dn_q <= (dn_q & ~both) | rf_p;
      end
   end
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
   parameter int PERIODS = 8,
   parameter int TOL     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic up,
   input  logic dn,
   input  logic ref_p,
   output logic locked
);
   localparam int WW = $clog2(TOL + 3);
   localparam int GW = $clog2(PERIODS + 1);

   logic [WW-1:0] wid_q;
   logic [WW-1:0] seen;
   logic [GW-1:0] good_q;
   logic          over;

   always_comb begin
      int s;
      s = int'(wid_q) + ((up | dn) ? 1 : 0);
      if (s > TOL + 1) s = TOL + 1;
      seen = WW'(s);
   end

   assign over   = int'(seen) > TOL;
   assign locked = int'(good_q) == PERIODS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wid_q  <= '0;
         good_q <= '0;
      end else if (!run) begin
         wid_q  <= '0;
         good_q <= '0;
      end else begin
         if (ref_p) wid_q <= '0;
         else       wid_q <= seen;
         if (over) begin
            good_q <= '0;
         end else if (ref_p && int'(good_q) < PERIODS) begin
            good_q <= good_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/synth_core.sv
module synth_core #(
   parameter int SF_W          = 15,
   parameter int REF_BASE_LOG2 = 8,
   parameter int LOCK_PERIODS  = 8,
   parameter int LOCK_TOL      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rf_tick,
   input  logic            ref_tick,
   input  logic [SF_W-1:0] div_ratio,
   input  logic [1:0]      ref_sel,
   input  logic            pump_off,
   input  logic            drive_off,
   input  logic            pump_hi,
   input  logic            test_route,
   output logic            pump_up,
   output logic            pump_dn,
   output logic            pump_en,
   output logic            pump_cur_hi,
   output logic            drive_en,
   output logic            lock_n,
   output logic            tp_rf,
   output logic            tp_ref
);
   if (SF_W < 2 || SF_W > 24) begin : g_bad_sf
      $error("synth_core: SF_W out of range");
   end
   if (REF_BASE_LOG2 < 1 || REF_BASE_LOG2 > 16) begin : g_bad_ref
      $error("synth_core: REF_BASE_LOG2 out of range");
   end
   if (LOCK_PERIODS < 1 || LOCK_TOL < 1) begin : g_bad_lock
      $error("synth_core: lock parameters must be positive");
   end

   logic loop_on;
   logic rf_p, ref_p;
   logic up_q, dn_q;
   logic locked;

   assign drive_en = ~drive_off & (div_ratio != '0);
   assign loop_on  = drive_en & (ref_sel != 2'b00);

   synth_rf_div #(.SF_W(SF_W)) u_rf_div (
      .clk(clk), .rst_n(rst_n), .run(loop_on), .tick(rf_tick),
      .ratio(div_ratio), .pulse(rf_p)
   );

   synth_ref_div #(.BASE_LOG2(REF_BASE_LOG2)) u_ref_div (
      .clk(clk), .rst_n(rst_n), .run(loop_on), .tick(ref_tick),
      .sel(ref_sel), .pulse(ref_p)
   );

   synth_pfd u_pfd (
      .clk(clk), .rst_n(rst_n), .run(loop_on),
      .ref_p(ref_p), .rf_p(rf_p), .up_q(up_q), .dn_q(dn_q)
   );

   synth_lock_det #(.PERIODS(LOCK_PERIODS), .TOL(LOCK_TOL)) u_lock (
      .clk(clk), .rst_n(rst_n), .run(loop_on),
      .up(up_q), .dn(dn_q), .ref_p(ref_p), .locked(locked)
   );

   assign pump_en     = loop_on & ~pump_off;
   assign pump_up     = up_q & pump_en;
   assign pump_dn     = dn_q & pump_en;
   assign pump_cur_hi = pump_hi & pump_en;
   assign lock_n      = ~locked;
   assign tp_rf       = test_route & rf_p;
   assign tp_ref      = test_route & ref_p;
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk #(
   parameter int SF_W = 15
) (
   input logic            clk,
   input logic            rst_n,
   input logic [SF_W-1:0] div_ratio,
   input logic [1:0]      ref_sel,
   input logic            pump_off,
   input logic            drive_off,
   input logic            test_route,
   input logic            pump_up,
   input logic            pump_dn,
   input logic            pump_en,
   input logic            lock_n,
   input logic            tp_rf,
   input logic            tp_ref
);
   always @(negedge clk) begin
      if (!rst_n) begin
         AST_RESET_IDLE: assert (lock_n && !pump_up && !pump_dn && !tp_rf && !tp_ref); // R1
      end
   end

   AST_PUMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pump_off |-> (!pump_en && !pump_up && !pump_dn)); // R5

   AST_DRIVE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      drive_off |=> (!pump_up && !pump_dn && lock_n && !tp_rf && !tp_ref)); // R6

   AST_ZERO_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
      (div_ratio == '0) |=> (!pump_up && !pump_dn && lock_n && !tp_rf)); // R7

   AST_REF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_sel == 2'b00) |=> (lock_n && !tp_ref)); // R3

   AST_TEST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !test_route |-> (!tp_rf && !tp_ref)); // R8
endmodule

bind synth_core synth_core_chk #(.SF_W(SF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .ref_sel(ref_sel),
   .pump_off(pump_off), .drive_off(drive_off), .test_route(test_route),
   .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
   .lock_n(lock_n), .tp_rf(tp_rf), .tp_ref(tp_ref)
);

// File: tb/synth_core_test.sv
module synth_core_test;
   localparam int SF_W = 15;
   localparam int B    = 2;
   localparam int NP   = 4;
   localparam int TOL  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rf_tick = 1'b0, ref_tick = 1'b0;
   logic [SF_W-1:0] div_ratio = '0;
   logic [1:0] ref_sel = 2'b00;
   logic pump_off = 1'b0, drive_off = 1'b0, pump_hi = 1'b0, test_route = 1'b0;
   logic pump_up, pump_dn, pump_en, pump_cur_hi, drive_en, lock_n, tp_rf, tp_ref;

   always #4 clk = ~clk;

   synth_core #(.SF_W(SF_W), .REF_BASE_LOG2(B), .LOCK_PERIODS(NP), .LOCK_TOL(TOL)) uut (
      .clk(clk), .rst_n(rst_n), .rf_tick(rf_tick), .ref_tick(ref_tick),
      .div_ratio(div_ratio), .ref_sel(ref_sel), .pump_off(pump_off),
      .drive_off(drive_off), .pump_hi(pump_hi), .test_route(test_route),
      .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
      .pump_cur_hi(pump_cur_hi), .drive_en(drive_en), .lock_n(lock_n),
      .tp_rf(tp_rf), .tp_ref(tp_ref)
   );

   // behavioural reference model
   int m_rfc, m_refc, m_w, m_good;
   bit m_rfp, m_refp, m_up, m_dn;

   function automatic bit model_active();
      return !drive_off && div_ratio != 0 && ref_sel != 2'b00;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || !model_active()) begin
         m_rfc = 0; m_refc = 0; m_w = 0; m_good = 0;
         m_rfp = 0; m_refp = 0; m_up = 0; m_dn = 0;
      end else begin
         int lim, seen;
         bit n_rfp, n_refp, n_up, n_dn, clr;
         lim = (ref_sel == 2'b01) ? (1 << (B + 2)) :
               (ref_sel == 2'b10) ? (1 << B) : (1 << (B + 1));
         n_rfp = 0; n_refp = 0;
         if (rf_tick) begin
            if (m_rfc + 1 >= int'(div_ratio)) begin m_rfc = 0; n_rfp = 1; end
            else m_rfc++;
         end
         if (ref_tick) begin
            if (m_refc + 1 >= lim) begin m_refc = 0; n_refp = 1; end
            else m_refc++;
         end
         clr  = m_up && m_dn;
         n_up = (m_up && !clr) || m_refp;
         n_dn = (m_dn && !clr) || m_rfp;
         seen = m_w + ((m_up || m_dn) ? 1 : 0);
         if (seen > TOL + 1) seen = TOL + 1;
         if (seen > TOL) m_good = 0;
         else if (m_refp && m_good < NP) m_good++;
         m_w = m_refp ? 0 : seen;
         m_rfp = n_rfp; m_refp = n_refp; m_up = n_up; m_dn = n_dn;
      end
   end

   int vectors = 0, errors = 0, cyc = 0, rf_per = 1;
   bit done = 0;
   string tag = "R1";
   bit lock_seen = 0, unlock_seen = 0;

   task automatic chk(input bit act, input bit exp, input string req, input string nm);
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s) %s actual=%0b expected=%0b cycle=%0d", req, tag, nm, act, exp, cyc);
      end
   endtask

   task automatic step();
      bit pe;
      @(negedge clk);
      vectors++;
      pe = model_active() && !pump_off;
      chk(pump_en,     pe,                      "R5", "pump_en");
      chk(pump_up,     m_up && pe,              "R4", "pump_up");
      chk(pump_dn,     m_dn && pe,              "R4", "pump_dn");
      chk(pump_cur_hi, pump_hi && pe,           "R9", "pump_cur_hi");
      chk(drive_en,    !drive_off && div_ratio != 0, "R6", "drive_en");
      chk(lock_n,      !(m_good == NP),         "R10", "lock_n");
      chk(tp_rf,       test_route && m_rfp,     "R2", "tp_rf");
      chk(tp_ref,      test_route && m_refp,    "R3", "tp_ref");
      if (!lock_n) lock_seen = 1;
      if (lock_seen && lock_n) unlock_seen = 1;
      cyc++;
      rf_tick  = (rf_per != 0) && (cyc % rf_per == 0);
      ref_tick = 1'b1;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      run(4);                       // R1 reset state
      rst_n = 1'b1;
      tag = "R10"; test_route = 1; pump_hi = 1;
      ref_sel = 2'b11; div_ratio = 8; rf_per = 1;
      run(120);
      vectors++;
      if (!lock_seen) begin errors++; $display("FAIL R10 lock never reached actual=1 expected=0"); end
      tag = "R11"; div_ratio = 9;   // drifting ratio breaks lock
      run(100);
      vectors++;
      if (!unlock_seen) begin errors++; $display("FAIL R11 lock never dropped actual=0 expected=1"); end
      tag = "R3"; ref_sel = 2'b01; div_ratio = 16; run(120);
      ref_sel = 2'b10; div_ratio = 2; rf_per = 2; run(80);
      ref_sel = 2'b00; run(20);     // stopped code
      tag = "R2"; ref_sel = 2'b11; div_ratio = 1; rf_per = 8; run(80);
      div_ratio = 3; rf_per = 3; run(80);
      tag = "R5"; pump_off = 1; run(40);
      tag = "R9"; pump_hi = 0; run(10); pump_off = 0; run(20); pump_hi = 1; run(10);
      tag = "R8"; test_route = 0; run(60); test_route = 1;
      tag = "R6"; drive_off = 1; run(30); drive_off = 0; run(60);
      tag = "R7"; div_ratio = 0; run(30); div_ratio = 3; run(60);
      tag = "R4"; rf_per = 0; run(40); rf_per = 1; div_ratio = 8; run(60);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL all watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule